// File: doc/BRIEF.md
# Selective TLB Invalidation Unit

This block is a small fully associative translation cache with a command port for refills, lookups, selective invalidations and a pair of fences that bracket a batch of invalidations. An invalidation carries a virtual page number, an address space identifier, and two flags. Each flag tells the block that the matching operand came from the zero register and should act as a wildcard. Every entry that the request selects is cleared in the same cycle, because all entries are compared in parallel.

A write-side fence opens a batch window and a read-side fence closes it. While the window is open, lookups always report a miss, so no translation that may be stale is used before the batch is closed. Refills replace entries in round-robin order. An invalidation only clears entries and imposes no other ordering.

Top module: `tlb_sel_inval`

## Requirements
- R1: While reset is held, `cmd_ready` is 0. After reset, no entry is valid, `batch_open` is 0 and `rsp_valid` is 0.
- R2: A lookup (`cmd_op`=0) accepted at a clock edge gives `rsp_valid`=1 after that edge for one cycle. It hits when a valid entry has an equal VPN and is either global or has an equal ASID. `rsp_ppn` carries the PPN of the lowest-index entry that matches, and is 0 on a miss. Other commands leave `rsp_valid` at 0.
- R3: A refill (`cmd_op`=1) writes VPN, ASID, PPN and the global flag into the entry at the replacement pointer. The pointer starts at index 0 and advances by one for each refill, wrapping from 7 back to 0.
- R4: An invalidate (`cmd_op`=2) with both wildcard flags clear removes the non-global valid entries whose VPN and ASID both equal the operands. No other entry is affected.
- R5: With `cmd_addr_zero`=1, an invalidate matches every VPN. Entries are still filtered by ASID unless `cmd_asid_zero` is set.
- R6: With `cmd_asid_zero`=1, an invalidate matches every ASID, including global entries. When `cmd_asid_zero`=0, global entries are never removed.
- R7: An invalidate with both wildcard flags set empties the whole cache.
- R8: A write-side fence (`cmd_op`=3) sets `batch_open` to 1 from the next cycle. While `batch_open` is 1, every lookup misses.
- R9: A read-side fence (`cmd_op`=4) clears `batch_open`. A read-side fence when no window is open changes nothing. Invalidates issued inside the window take effect exactly as they do outside it.
- R10: After reset, `cmd_ready` stays 1 in every cycle, so each command, an invalidate included, completes in one cycle.
- R11: Op codes 5 to 7 are accepted and have no effect on entries, on the window or on `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_op | input | 3 | 0 lookup, 1 refill, 2 invalidate, 3 write fence, 4 read fence |
| cmd_vpn | input | VPN_W | Virtual page number operand |
| cmd_asid | input | ASID_W | Address space identifier operand |
| cmd_addr_zero | input | 1 | Address operand was the zero register (all VPNs) |
| cmd_asid_zero | input | 1 | ASID operand was the zero register (all ASIDs) |
| cmd_ppn | input | PPN_W | Physical page number for refill |
| cmd_global | input | 1 | Global flag for refill |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_ppn | output | PPN_W | Translated page number on hit, 0 on miss |
| batch_open | output | 1 | Batch invalidation window is open |

## Verification
The assertions assume that `cmd_op` and the operand inputs are driven to known values whenever `cmd_valid` is high, and that refills may create duplicate VPN/ASID pairs, which the lowest-index rule resolves. The stimulus drives every field on the falling edge and holds it through the sampling edge. It keeps VPNs and ASIDs in narrow ranges so that hits, duplicates and wildcard overlaps come up often. It also mixes fence pairs, orphan read fences and unused op codes into the random stream.

// File: rtl/tlb_inv_pkg.sv
package tlb_inv_pkg;
  localparam int OP_W = 3;
  typedef enum logic [OP_W-1:0] {
    OP_LOOKUP  = 3'd0,
    OP_REFILL  = 3'd1,
    OP_INVAL   = 3'd2,
    OP_FENCE_W = 3'd3,
    OP_FENCE_R = 3'd4
  } cmd_op_e;
endpackage

// File: rtl/tlb_entry_match.sv
module tlb_entry_match #(
  parameter int VPN_W  = 20,
  parameter int ASID_W = 9
) (
  input  logic              e_valid,
  input  logic              e_global,
  input  logic [ASID_W-1:0] e_asid,
  input  logic [VPN_W-1:0]  e_vpn,
  input  logic [VPN_W-1:0]  q_vpn,
  input  logic [ASID_W-1:0] q_asid,
  input  logic              q_addr_zero,
  input  logic              q_asid_zero,
  output logic              lk_hit,
  output logic              inv_hit
);
  function automatic logic lookup_sel(input logic v, input logic g,
                                      input logic [ASID_W-1:0] ea, input logic [VPN_W-1:0] ev,
                                      input logic [ASID_W-1:0] qa, input logic [VPN_W-1:0] qv);
    return v && (ev == qv) && (g || (ea == qa));
  endfunction

  function automatic logic inval_sel(input logic v, input logic g,
                                     input logic [ASID_W-1:0] ea, input logic [VPN_W-1:0] ev,
                                     input logic [ASID_W-1:0] qa, input logic [VPN_W-1:0] qv,
                                     input logic az, input logic sz);
    logic addr_ok, asid_ok;
    addr_ok = az || (ev == qv);
    asid_ok = sz || (!g && (ea == qa));
    return v && addr_ok && asid_ok;
  endfunction

  assign lk_hit  = lookup_sel(e_valid, e_global, e_asid, e_vpn, q_asid, q_vpn);
  assign inv_hit = inval_sel(e_valid, e_global, e_asid, e_vpn, q_asid, q_vpn,
                             q_addr_zero, q_asid_zero);
endmodule

// File: rtl/tlb_rr_victim.sv
module tlb_rr_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  function automatic logic [IDX_W-1:0] next_ptr(input logic [IDX_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else if (adv) ptr <= next_ptr(ptr);
  end

  // R3
  rr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)));
endmodule

// File: rtl/tlb_batch_win.sv
module tlb_batch_win (
  input  logic clk,
  input  logic rst_n,
  input  logic open_req,
  input  logic close_req,
  output logic win_open
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         win_open <= 1'b0;
    else if (open_req)  win_open <= 1'b1;
    else if (close_req) win_open <= 1'b0;
  end

  // R8
  win_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_req |=> win_open);
  // R9
  win_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_req |=> !win_open);
  // R9
  win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_req && !close_req) |=> (win_open == $past(win_open)));
endmodule

// File: rtl/tlb_sel_inval.sv
module tlb_sel_inval
  import tlb_inv_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 9,
  parameter int PPN_W   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [VPN_W-1:0]  cmd_vpn,
  input  logic [ASID_W-1:0] cmd_asid,
  input  logic              cmd_addr_zero,
  input  logic              cmd_asid_zero,
  input  logic [PPN_W-1:0]  cmd_ppn,
  input  logic              cmd_global,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PPN_W-1:0]  rsp_ppn,
  output logic              batch_open
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // command decode, brought out as named events
  logic cmd_go, lookup_go, refill_go, inval_go, fence_w_go, fence_r_go;
  assign cmd_go     = cmd_valid && cmd_ready;
  assign lookup_go  = cmd_go && (cmd_op == OP_LOOKUP);
  assign refill_go  = cmd_go && (cmd_op == OP_REFILL);
  assign inval_go   = cmd_go && (cmd_op == OP_INVAL);
  assign fence_w_go = cmd_go && (cmd_op == OP_FENCE_W);
  assign fence_r_go = cmd_go && (cmd_op == OP_FENCE_R);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_ready <= 1'b0;
    else        cmd_ready <= 1'b1;
  end

  // entry storage
  logic [ENTRIES-1:0] ent_v, ent_g, lk_hit, inv_hit;
  logic [ASID_W-1:0]  ent_asid [ENTRIES];
  logic [VPN_W-1:0]   ent_vpn  [ENTRIES];
  logic [PPN_W-1:0]   ent_ppn  [ENTRIES];
  logic [IDX_W-1:0]   victim;

  tlb_rr_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .adv(refill_go), .ptr(victim)
  );

  tlb_batch_win u_win (
    .clk(clk), .rst_n(rst_n), .open_req(fence_w_go), .close_req(fence_r_go),
    .win_open(batch_open)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic wr_here;
    assign wr_here = refill_go && (victim == IDX_W'(i));

    tlb_entry_match #(.VPN_W(VPN_W), .ASID_W(ASID_W)) u_match (
      .e_valid(ent_v[i]), .e_global(ent_g[i]), .e_asid(ent_asid[i]), .e_vpn(ent_vpn[i]),
      .q_vpn(cmd_vpn), .q_asid(cmd_asid), .q_addr_zero(cmd_addr_zero),
      .q_asid_zero(cmd_asid_zero), .lk_hit(lk_hit[i]), .inv_hit(inv_hit[i])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_v[i] <= 1'b0;
      end else if (wr_here) begin
        ent_v[i] <= 1'b1;
      end else if (inval_go && inv_hit[i]) begin
        ent_v[i] <= 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_g[i]    <= 1'b0;
        ent_asid[i] <= '0;
        ent_vpn[i]  <= '0;
        ent_ppn[i]  <= '0;
      end else if (wr_here) begin
        ent_g[i]    <= cmd_global;
        ent_asid[i] <= cmd_asid;
        ent_vpn[i]  <= cmd_vpn;
        ent_ppn[i]  <= cmd_ppn;
      end
    end

    // R6
    global_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inval_go && !cmd_asid_zero && ent_v[i] && ent_g[i]) |=> ent_v[i]);
    // R4
    other_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inval_go && ent_v[i] && !cmd_addr_zero && (ent_vpn[i] != cmd_vpn)) |=> ent_v[i]);
  end

  // lowest-index hit selection
  logic             any_hit;
  logic [IDX_W-1:0] hit_idx;
  always_comb begin
    any_hit = |lk_hit;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_hit[i]) hit_idx = IDX_W'(i);
    end
  end

  logic use_hit;
  assign use_hit = any_hit && !batch_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_ppn   <= '0;
    end else begin
      rsp_valid <= lookup_go;
      rsp_hit   <= lookup_go && use_hit;
      rsp_ppn   <= (lookup_go && use_hit) ? ent_ppn[hit_idx] : '0;
    end
  end

  // R7
  wipe_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inval_go && cmd_addr_zero && cmd_asid_zero) |=> (ent_v == '0));
  // R8
  window_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_go && batch_open) |=> (rsp_valid && !rsp_hit));
  // R2
  rsp_only_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(lookup_go));
  // R2
  miss_ppn_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_ppn == '0));
  // R10
  ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cmd_ready);
endmodule

// File: tb/tb_tlb_sel_inval.sv
`timescale 1ns/1ps
module tb_tlb_sel_inval;
  localparam int N = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [19:0] cmd_vpn = '0, cmd_ppn = '0;
  logic [8:0] cmd_asid = '0;
  logic cmd_addr_zero = 1'b0, cmd_asid_zero = 1'b0, cmd_global = 1'b0;
  logic rsp_valid, rsp_hit, batch_open;
  logic [19:0] rsp_ppn;

  always #10 clk = ~clk;

  tlb_sel_inval dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_vpn(cmd_vpn), .cmd_asid(cmd_asid),
    .cmd_addr_zero(cmd_addr_zero), .cmd_asid_zero(cmd_asid_zero),
    .cmd_ppn(cmd_ppn), .cmd_global(cmd_global), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn), .batch_open(batch_open)
  );

  int checks = 0, errors = 0;
  bit m_v [N], m_g [N];
  logic [8:0]  m_a [N];
  logic [19:0] m_vpn [N], m_ppn [N];
  int m_ptr = 0;
  bit m_win = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // translation picks first slot whose page agrees and whose owner agrees or is shared
  function automatic int mdl_find(input logic [19:0] v, input logic [8:0] a);
    for (int k = 0; k < N; k++)
      if (m_v[k] && m_vpn[k] == v && (m_g[k] || m_a[k] == a)) return k;
    return -1;
  endfunction

  function automatic bit mdl_kill(input int k, input logic [19:0] v, input logic [8:0] a,
                                  input bit az, input bit sz);
    if (!m_v[k]) return 0;
    if (!az && m_vpn[k] != v) return 0;
    if (sz) return 1;
    return !m_g[k] && m_a[k] == a;
  endfunction

  task automatic issue(input logic [2:0] op, input logic [19:0] v, input logic [8:0] a,
                       input bit az, input bit sz, input logic [19:0] p, input bit g,
                       input string tag);
    int idx;
    bit eh;
    logic [19:0] ep;
    idx = mdl_find(v, a);
    eh  = (idx >= 0) && !m_win;
    ep  = eh ? m_ppn[idx] : 20'd0;
    chk(cmd_ready == 1'b1, {tag, " R10 ready"}, cmd_ready, 1);
    cmd_valid = 1'b1; cmd_op = op; cmd_vpn = v; cmd_asid = a;
    cmd_addr_zero = az; cmd_asid_zero = sz; cmd_ppn = p; cmd_global = g;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (op == 3'd0) begin
      chk(rsp_valid == 1'b1, {tag, " R2 rsp_valid"}, rsp_valid, 1);
      chk(rsp_hit == eh, {tag, " R2/R8 hit"}, rsp_hit, eh);
      chk(rsp_ppn == ep, {tag, " R2 ppn"}, rsp_ppn, ep);
    end else begin
      chk(rsp_valid == 1'b0, {tag, " R2/R11 no rsp"}, rsp_valid, 0);
    end
    case (op)
      3'd1: begin
        m_v[m_ptr] = 1; m_g[m_ptr] = g; m_a[m_ptr] = a;
        m_vpn[m_ptr] = v; m_ppn[m_ptr] = p;
        m_ptr = (m_ptr + 1) % N;
      end
      3'd2: for (int k = 0; k < N; k++) if (mdl_kill(k, v, a, az, sz)) m_v[k] = 0;
      3'd3: m_win = 1;
      3'd4: m_win = 0;
      default: ;
    endcase
    chk(batch_open == m_win, {tag, " R8/R9 window"}, batch_open, m_win);
  endtask

  task automatic look(input logic [19:0] v, input logic [8:0] a, input string tag);
    issue(3'd0, v, a, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b0, "R1 ready in reset", cmd_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 rsp idle", rsp_valid, 0);
    chk(batch_open == 1'b0, "R1 window closed", batch_open, 0);
    for (int k = 0; k < 4; k++) look(20'(k), 9'd1, "R1 empty");

    // R3 fill and wrap
    for (int k = 0; k < N; k++)
      issue(3'd1, 20'(k), 9'(1 + k % 2), 0, 0, 20'(16'hA00 + k), k == 3, "R3 fill");
    for (int k = 0; k < N; k++) look(20'(k), 9'(1 + k % 2), "R3 readback");
    look(20'd3, 9'd7, "R2 global any asid");
    look(20'd2, 9'd2, "R2 asid mismatch");
    issue(3'd1, 20'd100, 9'd1, 0, 0, 20'h55, 0, "R3 wrap");
    look(20'd0, 9'd1, "R3 slot0 replaced");
    look(20'd100, 9'd1, "R3 new entry");

    // R4 specific
    issue(3'd2, 20'd2, 9'd2, 0, 0, 0, 0, "R4 wrong asid");
    issue(3'd2, 20'd2, 9'd1, 0, 0, 0, 0, "R4 exact");
    look(20'd2, 9'd1, "R4 after");
    look(20'd4, 9'd1, "R4 neighbour");
    // R5 / R6
    issue(3'd2, 20'd0, 9'd2, 1, 0, 0, 0, "R5 all vpn asid2");
    look(20'd1, 9'd2, "R5 cleared");
    look(20'd3, 9'd2, "R6 global kept");
    look(20'd4, 9'd1, "R5 other asid kept");
    issue(3'd2, 20'd3, 9'd0, 0, 1, 0, 0, "R6 asid wildcard");
    look(20'd3, 9'd2, "R6 global cleared");
    // R7
    issue(3'd2, 20'd0, 9'd0, 1, 1, 0, 0, "R7 wipe");
    for (int k = 0; k < N; k++) look(20'(k), 9'(1 + k % 2), "R7 empty");

    // R8 / R9 window
    issue(3'd1, 20'd9, 9'd3, 0, 0, 20'h99, 0, "R8 refill");
    issue(3'd4, 0, 0, 0, 0, 0, 0, "R9 orphan read fence");
    look(20'd9, 9'd3, "R9 orphan no effect");
    issue(3'd3, 0, 0, 0, 0, 0, 0, "R8 open");
    look(20'd9, 9'd3, "R8 blocked");
    issue(3'd1, 20'd10, 9'd3, 0, 0, 20'hAA, 0, "R8 refill in window");
    issue(3'd2, 20'd9, 9'd3, 0, 0, 0, 0, "R9 inval in window");
    issue(3'd4, 0, 0, 0, 0, 0, 0, "R9 close");
    look(20'd9, 9'd3, "R9 inval took effect");
    look(20'd10, 9'd3, "R9 reopened");
    // R11
    for (int c = 5; c < 8; c++) issue(3'(c), 20'd10, 9'd3, 1, 1, 0, 0, "R11 unused op");
    look(20'd10, 9'd3, "R11 entries intact");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int r;
      logic [2:0] op;
      r = $urandom_range(0, 99);
      op = (r < 40) ? 3'd0 : (r < 65) ? 3'd1 : (r < 85) ? 3'd2 :
           (r < 91) ? 3'd3 : (r < 97) ? 3'd4 : 3'(5 + $urandom_range(0, 2));
      issue(op, 20'($urandom_range(0, 7)), 9'($urandom_range(0, 3)),
            $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
            20'($urandom_range(0, 20'hFFFFF)), $urandom_range(0, 4) == 0, "RND");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule